// File: doc/BRIEF.md
# Receive Cell Port, PHY Side

This block is the PHY end of a byte-wide receive cell port. A line-side writer pushes ATM cell bytes into an internal receive FIFO. An ATM layer device drains that FIFO through an active-low read enable. It watches a cell-available flag to know when data is waiting. The flag can signal either "at least one byte present" or "at least one full 53-byte cell present", as configured.

When several PHY ports share one bus, the block can run in multi-PHY mode. In that mode its flag and data drivers are enabled only while the polled address matches the configured port address. The flag then always uses the full-cell rule. Tri-state drivers appear as a value plus an output-enable pin, so that the board or pad ring can combine them.

Top module: `utopia_rx_phy`

## Requirements
- R1: With cfg_multi_phy=0 and cfg_cell_mode=0, clav is 1 exactly when the FIFO holds one or more bytes, and clav_oe is 1.
- R2: With cfg_multi_phy=0 and cfg_cell_mode=1, clav is 1 exactly when the FIFO holds 53 or more bytes, and clav_oe is 1.
- R3: With cfg_multi_phy=1, clav_oe is 1 in a cycle only if phy_addr (5 bits, bit 0 least significant) equalled cfg_phy_addr at the preceding clock edge; otherwise it is 0.
- R4: With cfg_multi_phy=1 and the port selected, clav follows the 53-byte rule whatever cfg_cell_mode holds.
- R5: rx_data_oe is 1 exactly when rd_en_n is 0, and in multi-PHY mode the port is also selected; rd_en_n=1 always gives rx_data_oe=0.
- R6: An enabled read at a clock edge with a non-empty FIFO pops the oldest byte and presents it on rx_data after that edge. Bytes leave in the order they were written.
- R7: An enabled read with an empty FIFO pops nothing and leaves rx_data unchanged. It sets underrun, which stays 1 until reset.
- R8: The FIFO holds DEPTH (default 256) bytes. A write at an edge where it is full is dropped and sets overflow, which stays 1 until reset.
- R9: In multi-PHY mode, a read while the port is not selected pops nothing and leaves rx_data unchanged.
- R10: After reset the FIFO is empty, clav=0, rx_data=0, rx_data_oe follows rd_en_n, and underrun and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cell_mode | input | 1 | 1 = full-cell flag rule, 0 = any-byte rule |
| cfg_multi_phy | input | 1 | 1 = shared-bus mode with address select |
| cfg_phy_addr | input | 5 | Address this port answers to |
| wr_en | input | 1 | Line-side write strobe, one byte per clock |
| wr_data | input | 8 | Line-side byte |
| rd_en_n | input | 1 | Read enable from the layer device, active low |
| phy_addr | input | 5 | Polled port address |
| clav | output | 1 | Cell-available flag value |
| clav_oe | output | 1 | Drive enable for clav |
| rx_data | output | 8 | Receive data bus value |
| rx_data_oe | output | 1 | Drive enable for rx_data |
| underrun | output | 1 | Sticky: read attempted on empty FIFO |
| overflow | output | 1 | Sticky: write dropped on full FIFO |

## Verification
A corrupted fill count shows up at clav on the same cycle. It appears at the 0/1 boundary in byte mode and at the 52/53 boundary in cell mode. So both thresholds are crossed in each direction. A pointer fault shows up as a wrong or reordered byte on rx_data one edge after the bad pop. A stale select register shows up on clav_oe and as a missing or extra pop one cycle after an address change. Every output is compared against a queue model on every cycle, so any divergence is caught within one clock.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
   localparam int unsigned CELL_LEN_DEF = 53;
   localparam int unsigned MIN_CELLS    = 4;

   typedef enum logic [1:0] {
      RULE_BYTE  = 2'd0,
      RULE_CELL  = 2'd1,
      RULE_SHARE = 2'd2
   } flag_rule_e;
endpackage

// File: rtl/utopia_rx_fifo.sv
module utopia_rx_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 256,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  fill,
   output logic              underrun,
   output logic              overflow
);
   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              is_full, is_empty, do_push, do_pop;

   generate
      if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("utopia_rx_fifo: DEPTH must be a power of two");
      end
   endgenerate

   assign is_full  = (fill == CNT_W'(DEPTH));
   assign is_empty = (fill == '0);
   assign do_push  = wr_en && !is_full;
   assign do_pop   = rd_req && !is_empty;

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         fill     <= '0;
         rd_data  <= '0;
         underrun <= 1'b0;
         overflow <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop) begin
            rd_ptr  <= rd_ptr + 1'b1;
            rd_data <= store[rd_ptr];
         end
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
         if (rd_req && is_empty) underrun <= 1'b1;
         if (wr_en && is_full)   overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/utopia_rx_sel.sv
module utopia_rx_sel #(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [ADDR_W-1:0] poll_addr,
   output logic              selected
);
   logic [ADDR_W-1:0] bit_eq;

   generate
      for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
         assign bit_eq[i] = ~(own_addr[i] ^ poll_addr[i]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) selected <= 1'b0;
      else        selected <= &bit_eq;
   end
endmodule

// File: rtl/utopia_rx_flag.sv
module utopia_rx_flag
   import utopia_rx_pkg::*;
#(
   parameter int unsigned CNT_W      = 9,
   parameter int unsigned CELL_BYTES = 53
) (
   input  logic             cell_mode,
   input  logic             multi_phy,
   input  logic             selected,
   input  logic             rd_en_n,
   input  logic [CNT_W-1:0] fill,
   output logic             clav,
   output logic             clav_oe,
   output logic             rd_req,
   output logic             data_oe
);
   flag_rule_e rule;
   logic       has_byte, has_cell, port_on;

   assign has_byte = (fill != '0);
   assign has_cell = (fill >= CNT_W'(CELL_BYTES));
   assign port_on  = !multi_phy || selected;

   always_comb begin
      if (multi_phy)      rule = RULE_SHARE;
      else if (cell_mode) rule = RULE_CELL;
      else                rule = RULE_BYTE;
   end

   always_comb begin
      case (rule)
         RULE_BYTE: clav = has_byte;
         default:   clav = has_cell;
      endcase
   end

   assign clav_oe = port_on;
   assign data_oe = !rd_en_n && port_on;
   assign rd_req  = data_oe;
endmodule

// File: rtl/utopia_rx_phy.sv
module utopia_rx_phy
   import utopia_rx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned CELL_BYTES = CELL_LEN_DEF,
   parameter int unsigned DEPTH      = 256,
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cell_mode,
   input  logic              cfg_multi_phy,
   input  logic [ADDR_W-1:0] cfg_phy_addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en_n,
   input  logic [ADDR_W-1:0] phy_addr,
   output logic              clav,
   output logic              clav_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_data_oe,
   output logic              underrun,
   output logic              overflow
);
   generate
      if (DEPTH < MIN_CELLS * CELL_BYTES) begin : g_bad_room
         $error("utopia_rx_phy: DEPTH below four cells");
      end
   endgenerate

   logic [CNT_W-1:0] fill_cnt;
   logic             port_sel, rd_req;

   utopia_rx_sel #(.ADDR_W(ADDR_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .own_addr(cfg_phy_addr),
      .poll_addr(phy_addr), .selected(port_sel)
   );

   utopia_rx_flag #(.CNT_W(CNT_W), .CELL_BYTES(CELL_BYTES)) u_flag (
      .cell_mode(cfg_cell_mode), .multi_phy(cfg_multi_phy),
      .selected(port_sel), .rd_en_n(rd_en_n), .fill(fill_cnt),
      .clav(clav), .clav_oe(clav_oe), .rd_req(rd_req),
      .data_oe(rx_data_oe)
   );

   utopia_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_req(rd_req), .rd_data(rx_data), .fill(fill_cnt),
      .underrun(underrun), .overflow(overflow)
   );
endmodule

// File: rtl/utopia_rx_phy_chk.sv
module utopia_rx_phy_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned CELL_BYTES = 53,
   parameter int unsigned CNT_W      = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_cell_mode,
   input logic              cfg_multi_phy,
   input logic [ADDR_W-1:0] cfg_phy_addr,
   input logic [ADDR_W-1:0] phy_addr,
   input logic              rd_en_n,
   input logic              clav,
   input logic              clav_oe,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_data_oe,
   input logic              underrun,
   input logic              overflow,
   input logic [CNT_W-1:0]  fill_cnt
);
   AST_SEL_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_multi_phy && phy_addr == cfg_phy_addr) |=> clav_oe); // R3
   AST_DESEL_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_multi_phy && phy_addr != cfg_phy_addr) |=> (!cfg_multi_phy || !clav_oe)); // R3
   AST_CELL_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_multi_phy || cfg_cell_mode) && clav) |-> fill_cnt >= CNT_W'(CELL_BYTES)); // R4
   AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_n |-> !rx_data_oe); // R5
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_data_oe |=> $stable(rx_data)); // R9
   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun); // R7
   AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R8
endmodule

bind utopia_rx_phy utopia_rx_phy_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CELL_BYTES(CELL_BYTES), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_cell_mode(cfg_cell_mode),
   .cfg_multi_phy(cfg_multi_phy), .cfg_phy_addr(cfg_phy_addr),
   .phy_addr(phy_addr), .rd_en_n(rd_en_n), .clav(clav), .clav_oe(clav_oe),
   .rx_data(rx_data), .rx_data_oe(rx_data_oe), .underrun(underrun),
   .overflow(overflow), .fill_cnt(fill_cnt)
);

// File: tb/utopia_rx_phy_bench.sv
`timescale 1ns/1ps
module utopia_rx_phy_bench;
   localparam int DEPTH = 256;
   localparam int CELL  = 53;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_cell_mode = 1'b0, cfg_multi_phy = 1'b0;
   logic [4:0] cfg_phy_addr = 5'h13, phy_addr = 5'h00;
   logic       wr_en = 1'b0, rd_en_n = 1'b1;
   logic [7:0] wr_data = 8'h00;
   logic       clav, clav_oe, rx_data_oe, underrun, overflow;
   logic [7:0] rx_data;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   always #2 clk = ~clk;

   utopia_rx_phy u_utopia_rx_phy (
      .clk(clk), .rst_n(rst_n), .cfg_cell_mode(cfg_cell_mode),
      .cfg_multi_phy(cfg_multi_phy), .cfg_phy_addr(cfg_phy_addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en_n(rd_en_n),
      .phy_addr(phy_addr), .clav(clav), .clav_oe(clav_oe),
      .rx_data(rx_data), .rx_data_oe(rx_data_oe),
      .underrun(underrun), .overflow(overflow)
   );

   // Behavioural reference model
   byte unsigned q[$];
   logic [7:0] m_data;
   bit m_sel, m_under, m_over;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); m_data = 8'h00; m_sel = 0; m_under = 0; m_over = 0;
      end else begin
         bit en_rd, was_full;
         en_rd    = !rd_en_n && (!cfg_multi_phy || m_sel);
         was_full = (q.size() == DEPTH);
         if (en_rd && q.size() == 0) m_under = 1;
         if (en_rd && q.size() > 0) m_data = q.pop_front();
         if (wr_en && was_full) m_over = 1;
         if (wr_en && !was_full) q.push_back(wr_data);
         m_sel = (phy_addr == cfg_phy_addr);
      end
   end

   task automatic cmp(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      bit e_clav, e_coe, e_doe;
      string ctag;
      e_clav = (cfg_multi_phy || cfg_cell_mode) ? (q.size() >= CELL) : (q.size() > 0);
      e_coe  = cfg_multi_phy ? m_sel : 1'b1;
      e_doe  = !rd_en_n && (!cfg_multi_phy || m_sel);
      ctag   = cfg_multi_phy ? "R4 clav" : (cfg_cell_mode ? "R2 clav" : "R1 clav");
      cmp(cfg_multi_phy ? "R3 clav_oe" : "R1 clav_oe", clav_oe, e_coe);
      if (e_coe) cmp(ctag, clav, e_clav);
      cmp("R5 rx_data_oe", rx_data_oe, e_doe);
      cmp("R6 R7 R9 rx_data", rx_data, m_data);
      cmp("R7 underrun", underrun, m_under);
      cmp("R8 overflow", overflow, m_over);
   endtask

   // one cycle: compare at the falling edge, then drive the next inputs
   task automatic step(input bit w, input logic [7:0] d, input bit rn, input logic [4:0] a);
      @(negedge clk);
      check_all();
      wr_en = w; wr_data = d; rd_en_n = rn; phy_addr = a;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      cmp("R10 clav", clav, 0);
      cmp("R10 rx_data", rx_data, 0);
      cmp("R10 rx_data_oe", rx_data_oe, 0);
      cmp("R10 flags", {underrun, overflow}, 0);

      // R1 byte mode: three bytes in, read them back, then read empty (R7)
      for (int i = 0; i < 3; i++) step(1, 8'(8'hA0 + i), 1, 0);
      step(0, 0, 1, 0);
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0);
      step(0, 0, 1, 0);

      // R2 cell mode: 52 bytes keep clav low, the 53rd raises it
      cfg_cell_mode = 1'b1;
      for (int i = 0; i < 54; i++) step(1, 8'(i * 7 + 3), 1, 0);
      step(0, 0, 1, 0);
      // read down through the threshold while writing (simultaneous push/pop)
      for (int i = 0; i < 4; i++) step(i[0], 8'(i + 8'h55), 0, 0);
      for (int i = 0; i < 60; i++) step(0, 0, 0, 0);

      // R8 fill to capacity and beyond
      cfg_cell_mode = 1'b0;
      for (int i = 0; i < DEPTH + 3; i++) step(1, 8'(i * 13 + 1), 1, 0);
      step(1, 8'hEE, 0, 0);
      step(0, 0, 1, 0);
      for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0);
      step(0, 0, 1, 0);

      // R3 R4 R9 multi-PHY
      for (int i = 0; i < 60; i++) step(1, 8'(i * 5 + 9), 1, 5'h02);
      step(0, 0, 1, 5'h02);
      cfg_multi_phy = 1'b1;
      for (int i = 0; i < 4; i++) step(0, 0, 0, 5'h02);
      for (int i = 0; i < 20; i++) step(0, 0, 0, 5'h13);
      step(0, 0, 1, 5'h13);
      step(0, 0, 1, 5'h07);
      step(0, 0, 0, 5'h07);
      step(0, 0, 0, 5'h13);
      for (int i = 0; i < 40; i++) step(0, 0, 0, 5'h13);
      step(0, 0, 1, 5'h13);
      step(0, 0, 1, 5'h00);
      step(0, 0, 1, 5'h00);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule